// File: doc/BRIEF.md
# Flash Embedded-Operation Status Flag Generator

This block is a synthesizable device-side model of the status word that a parallel NOR flash places on its data bus while an internal program or erase runs. It samples the chip-enable, output-enable and write-enable strobes on the system clock. It counts write pulses to recognise program and erase command sequences. While an operation is in progress, it answers read cycles with a status byte instead of array contents.

The status byte has three flags. The first is a toggle flag that inverts on every new read access. The second is a limit flag that latches when the array sequencer reports that its internal pulse budget has run out. The third is a timer flag that reads 0 while the sector-erase collection window is still open. The block also models timed fake-busy periods for protected targets, erase suspend and resume, and a reset command that clears a latched fault. All durations are parameters counted in clock cycles. The memory array itself lies outside the block: its read data enters on `array_data` and passes through whenever the block is not busy.

Top module: `flash_busy_flags`

## Requirements
- R1: Out of reset, and whenever no operation is busy, `dout` equals `array_data`. `dout_en` is high exactly when both `ce_n` and `oe_n` are low.
- R2: A write pulse is a rising edge of `we_n` while `ce_n` is low. Pulses 1 and 2 may carry any data. If pulse 3 carries 0xA0, pulse 4 starts a program at the clock edge that detects the pulse. The program stays busy for PROG_CYC cycles, or for PROT_PROG_CYC cycles if `sec_prot` is high at that pulse. It then returns to R1 behaviour.
- R3: If pulse 3 carries 0x80, pulses 4 and 5 may carry any data, and pulse 6 selects the erase. A value of 0x10 on pulse 6 starts a chip erase that is busy for ERASE_CYC cycles, or for PROT_ERASE_CYC cycles if `sec_prot` is high. A value of 0x30 on pulse 6 starts a sector erase (R6).
- R4: While busy, the status byte on `dout` has bit 7 = 0, bit 6 = toggle flag, bit 5 = limit flag and bit 3 = timer flag. Bits 4, 2, 1 and 0 are 0.
- R5: While busy, each read start inverts the toggle flag. A read start is a fall of `oe_n` while `ce_n` is low, or a fall of `ce_n` while `oe_n` is low. While not busy, the toggle flag holds its value. It resets to 0, so the first busy read after reset shows 1.
- R6: A sector erase first opens a window of WINDOW_CYC cycles in which the status reads as busy with bit 3 = 0. A single write of 0x30 inside the window adds a sector and restarts the window. When the window closes, bit 3 reads 1. The erase then runs for ERASE_CYC cycles if any added sector had `sec_prot` low, and for PROT_ERASE_CYC cycles otherwise.
- R7: If `limit_hit` is high during a program or an erase, the block enters a fault state. In this state bit 5 reads 1 and the block stays busy, with the toggle flag advancing on every read, until a write of 0xF0. Outside a program or an erase, `limit_hit` has no effect.
- R8: A write of 0xB0 during a running erase (window closed) suspends it: `dout` shows `array_data` and the remaining time is frozen. A later write of 0x30 resumes the erase with the remaining time.
- R9: A write of 0xF0 at any point of a command sequence returns the pulse count to zero. Other data on pulse 3 aborts the sequence, and so does any value other than 0x10 or 0x30 on pulse 6 of an erase. Writes during a program are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; data captured on its rising edge |
| wr_data | input | 8 | Command byte for the current write pulse |
| sec_prot | input | 1 | Protection state of the sector addressed by the current write |
| limit_hit | input | 1 | Array sequencer reports its pulse budget exhausted |
| array_data | input | 8 | Array read data, passed through when not busy |
| dout | output | 8 | Read data or status byte |
| dout_en | output | 1 | Bus drive enable |

## Verification
The bench builds the block with PROG_CYC=12, PROT_PROG_CYC=5, ERASE_CYC=40, PROT_ERASE_CYC=20 and WINDOW_CYC=10. These values are short enough to check every busy period at its last busy cycle and at its first idle cycle. They also leave room to sweep all combinations of protected and unprotected targets for program, chip erase and sector erase, including a window restart by a second sector. The short erase further leaves room to suspend an erase partway through and to compute the resume end cycle exactly. Alternating reads through each strobe, a fault held well beyond the normal time, and aborted or reset command sequences all fit in a run of a few thousand cycles.

// File: rtl/flash_busy_flags.sv
module flash_busy_flags #(
  parameter int PROG_CYC       = 200,
  parameter int PROT_PROG_CYC  = 20,
  parameter int ERASE_CYC      = 5000,
  parameter int PROT_ERASE_CYC = 1000,
  parameter int WINDOW_CYC     = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic [7:0] wr_data,
  input  logic       sec_prot,
  input  logic       limit_hit,
  input  logic [7:0] array_data,
  output logic [7:0] dout,
  output logic       dout_en
);
  localparam int M1 = PROG_CYC > PROT_PROG_CYC ? PROG_CYC : PROT_PROG_CYC;
  localparam int M2 = ERASE_CYC > PROT_ERASE_CYC ? ERASE_CYC : PROT_ERASE_CYC;
  localparam int M3 = M1 > M2 ? M1 : M2;
  localparam int MAXC = M3 > WINDOW_CYC ? M3 : WINDOW_CYC;
  localparam int TW = $clog2(MAXC + 1);

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_PROG  = 3'd1;
  localparam logic [2:0] S_WIN   = 3'd2;
  localparam logic [2:0] S_ERASE = 3'd3;
  localparam logic [2:0] S_SUSP  = 3'd4;
  localparam logic [2:0] S_FAULT = 3'd5;

  localparam logic [7:0] C_RESET = 8'hF0;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_ERPRE = 8'h80;
  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_SUSP  = 8'hB0;

  logic [2:0]    state;
  logic [TW-1:0] timer;
  logic [2:0]    pcnt;
  logic          is_erase;
  logic          any_open;
  logic          tgl;
  logic          ce_q, oe_q, we_q;

  wire wr   = we_n & ~we_q & ~ce_n;
  wire rd   = ~ce_n & ~oe_n & (ce_q | oe_q);
  wire busy = (state == S_PROG) || (state == S_WIN) ||
              (state == S_ERASE) || (state == S_FAULT);
  wire tmo  = (timer == '0);

  assign dout_en = ~ce_n & ~oe_n;
  assign dout = busy ? {1'b0, tgl, state == S_FAULT, 1'b0, state == S_ERASE, 3'b000}
                     : array_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      timer    <= '0;
      pcnt     <= '0;
      is_erase <= 1'b0;
      any_open <= 1'b0;
      tgl      <= 1'b0;
      ce_q     <= 1'b1;
      oe_q     <= 1'b1;
      we_q     <= 1'b1;
    end else begin
      ce_q <= ce_n;
      oe_q <= oe_n;
      we_q <= we_n;
      if (busy && rd) tgl <= ~tgl;
      case (state)
        S_IDLE: if (wr) begin
          if (wr_data == C_RESET) pcnt <= '0;
          else case (pcnt)
            3'd2: begin
              if (wr_data == C_PROG) begin
                is_erase <= 1'b0;
                pcnt     <= 3'd3;
              end else if (wr_data == C_ERPRE) begin
                is_erase <= 1'b1;
                pcnt     <= 3'd3;
              end else pcnt <= '0;
            end
            3'd3: begin
              if (!is_erase) begin
                state <= S_PROG;
                timer <= sec_prot ? TW'(PROT_PROG_CYC - 1) : TW'(PROG_CYC - 1);
                pcnt  <= '0;
              end else pcnt <= 3'd4;
            end
            3'd5: begin
              pcnt <= '0;
              if (wr_data == C_CHIP) begin
                state <= S_ERASE;
                timer <= sec_prot ? TW'(PROT_ERASE_CYC - 1) : TW'(ERASE_CYC - 1);
              end else if (wr_data == C_SECT) begin
                state    <= S_WIN;
                timer    <= TW'(WINDOW_CYC - 1);
                any_open <= ~sec_prot;
              end
            end
            default: pcnt <= pcnt + 3'd1;
          endcase
        end
        S_PROG: begin
          if (limit_hit) state <= S_FAULT;
          else if (tmo) state <= S_IDLE;
          else timer <= timer - 1'b1;
        end
        S_WIN: begin
          if (wr && wr_data == C_SECT) begin
            timer    <= TW'(WINDOW_CYC - 1);
            any_open <= any_open | ~sec_prot;
          end else if (tmo) begin
            state <= S_ERASE;
            timer <= any_open ? TW'(ERASE_CYC - 1) : TW'(PROT_ERASE_CYC - 1);
          end else timer <= timer - 1'b1;
        end
        S_ERASE: begin
          if (limit_hit) state <= S_FAULT;
          else if (wr && wr_data == C_SUSP) state <= S_SUSP;
          else if (tmo) state <= S_IDLE;
          else timer <= timer - 1'b1;
        end
        S_SUSP: if (wr && wr_data == C_SECT) state <= S_ERASE;
        S_FAULT: if (wr && wr_data == C_RESET) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_busy_flags_chk.sv
module flash_busy_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state,
  input logic       busy,
  input logic       tgl,
  input logic       wr,
  input logic       rd,
  input logic [7:0] wr_data
);
  localparam logic [2:0] K_WIN   = 3'd2;
  localparam logic [2:0] K_ERASE = 3'd3;
  localparam logic [2:0] K_SUSP  = 3'd4;
  localparam logic [2:0] K_FAULT = 3'd5;

  // R2
  start_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr));

  // R5
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(tgl));

  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd) |=> (tgl != $past(tgl)));

  // R6
  window_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == K_WIN) |=> (state == K_WIN || state == K_ERASE));

  // R7
  fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == K_FAULT && !(wr && wr_data == 8'hF0)) |=> (state == K_FAULT));

  // R8
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == K_SUSP && !(wr && wr_data == 8'h30)) |=> (state == K_SUSP));
endmodule

bind flash_busy_flags flash_busy_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .busy(busy),
  .tgl(tgl), .wr(wr), .rd(rd), .wr_data(wr_data)
);

// File: tb/tb_flash_busy_flags.sv
module tb_flash_busy_flags;
  localparam int P = 12, PP = 5, E = 40, PE = 20, W = 10;
  localparam logic [7:0] ARR = 8'h81;

  logic clk = 0, rst_n = 0, ce_n = 0, oe_n = 1, we_n = 1;
  logic [7:0] wr_data = 8'h00;
  logic sec_prot = 0, limit_hit = 0;
  logic [7:0] array_data = ARR;
  logic [7:0] dout;
  logic dout_en;

  int cyc = 0, t_last = 0, checks = 0, errors = 0;
  bit done = 0;

  flash_busy_flags #(.PROG_CYC(P), .PROT_PROG_CYC(PP), .ERASE_CYC(E),
                     .PROT_ERASE_CYC(PE), .WINDOW_CYC(W)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wr_data(wr_data), .sec_prot(sec_prot), .limit_hit(limit_hit),
    .array_data(array_data), .dout(dout), .dout_en(dout_en));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic p = 0);
    @(negedge clk); we_n = 0; wr_data = d; sec_prot = p;
    @(negedge clk); we_n = 1;
    @(negedge clk); t_last = cyc;
  endtask

  task automatic rd_oe(output logic [7:0] v);
    @(negedge clk); oe_n = 0;
    @(negedge clk); v = dout; oe_n = 1;
  endtask

  task automatic rd_ce(output logic [7:0] v);
    @(negedge clk); oe_n = 0; ce_n = 1;
    @(negedge clk); ce_n = 0;
    @(negedge clk); v = dout; oe_n = 1;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic prog_cmd(input logic p);
    wr(8'hAA); wr(8'h55); wr(8'hA0); wr(8'h3C, p);
  endtask

  task automatic erase_cmd(input logic [7:0] last, input logic p);
    wr(8'hAA); wr(8'h55); wr(8'h80); wr(8'hAA); wr(8'h55); wr(last, p);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, prev;
    int t0, t1, ts, s, u, n;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset dout", dout, ARR);
    chk("R1 reset dout_en", {7'd0, dout_en}, 8'd0);
    rd_oe(v);
    chk("R1 idle read", v, ARR);

    // R2 program sweep, R4 status format
    for (int p = 0; p < 2; p++) begin
      n = p ? PP : P;
      prog_cmd(p[0]); t0 = t_last;
      chk("R4 busy status format", dout & 8'hBF, 8'h00);
      wait_to(t0 + n - 1);
      chk("R2 busy at last cycle", {7'd0, dout[7]}, 8'd0);
      wait_to(t0 + n);
      chk("R2 idle after program", dout, ARR);
    end

    // R5 toggle via both strobes during chip erase, R3
    erase_cmd(8'h10, 1'b0); t0 = t_last;
    rd_oe(v);
    chk("R5 first busy read", {7'd0, v[6]}, 8'd1);
    prev = v;
    for (int i = 0; i < 3; i++) begin
      rd_oe(v);
      chk("R5 oe toggle", {7'd0, v[6]}, {7'd0, ~prev[6]});
      prev = v;
    end
    for (int i = 0; i < 2; i++) begin
      rd_ce(v);
      chk("R5 ce toggle", {7'd0, v[6]}, {7'd0, ~prev[6]});
      prev = v;
    end
    chk("R4 chip erase dq3", {7'd0, v[3]}, 8'd1);
    wait_to(t0 + E - 1);
    chk("R3 chip erase busy", {7'd0, dout[7]}, 8'd0);
    wait_to(t0 + E);
    chk("R3 chip erase idle", dout, ARR);
    for (int i = 0; i < 3; i++) begin
      rd_oe(v);
      chk("R1 idle read passthrough", v, ARR);
    end
    prog_cmd(1'b0); t0 = t_last;
    rd_oe(v);
    chk("R5 toggle held while idle", {7'd0, v[6]}, {7'd0, ~prev[6]});
    wait_to(t0 + P);

    // R3 protected chip erase
    erase_cmd(8'h10, 1'b1); t0 = t_last;
    wait_to(t0 + PE - 1);
    chk("R3 protected chip erase busy", {7'd0, dout[7]}, 8'd0);
    wait_to(t0 + PE);
    chk("R3 protected chip erase idle", dout, ARR);

    // R6 sector erase sweep: first protection, optional added sector
    for (int nadd = 0; nadd < 2; nadd++)
      for (int p0 = 0; p0 < 2; p0++)
        for (int p1 = 0; p1 < 2; p1++) begin
          if (nadd == 0 && p1 == 1) continue;
          erase_cmd(8'h30, p0[0]); t1 = t_last;
          chk("R6 window dq3 low", dout & 8'hBF, 8'h00);
          if (nadd == 1) begin
            wait_to(t1 + 4);
            wr(8'h30, p1[0]); t1 = t_last;
          end
          n = (p0 == 0 || (nadd == 1 && p1 == 0)) ? E : PE;
          wait_to(t1 + W - 1);
          chk("R6 window still open", dout & 8'hBF, 8'h00);
          wait_to(t1 + W);
          chk("R6 window closed", dout & 8'hBF, 8'h08);
          wait_to(t1 + W + n - 1);
          chk("R6 erase busy", {7'd0, dout[7]}, 8'd0);
          wait_to(t1 + W + n);
          chk("R6 erase idle", dout, ARR);
        end

    // R7 fault latch
    @(negedge clk); limit_hit = 1; @(negedge clk); limit_hit = 0;
    chk("R7 limit ignored when idle", dout, ARR);
    prog_cmd(1'b0); t0 = t_last;
    wait_to(t0 + 2);
    limit_hit = 1; @(negedge clk); limit_hit = 0;
    wait_to(t0 + P + 10);
    chk("R7 fault status", dout & 8'hBF, 8'h20);
    rd_oe(prev);
    rd_oe(v);
    chk("R7 fault toggles", {7'd0, v[6]}, {7'd0, ~prev[6]});
    wr(8'hF0);
    chk("R7 reset clears fault", dout, ARR);

    // R8 suspend / resume
    erase_cmd(8'h10, 1'b0); ts = t_last;
    wait_to(ts + 10);
    wr(8'hB0); s = t_last;
    chk("R8 suspended reads array", dout, ARR);
    wait_to(s + 15);
    chk("R8 still suspended", dout, ARR);
    wr(8'h30); u = t_last;
    chk("R8 resumed busy", {7'd0, dout[7]}, 8'd0);
    wait_to(u + E - (s - ts));
    chk("R8 busy before end", {7'd0, dout[7]}, 8'd0);
    wait_to(u + E - (s - ts) + 1);
    chk("R8 idle after remaining time", dout, ARR);

    // R9 reset command and aborted sequences
    wr(8'hAA); wr(8'h55); wr(8'hF0); wr(8'hA0); wr(8'h3C);
    chk("R9 reset cleared count", dout, ARR);
    wr(8'h77);
    chk("R9 bad third pulse aborts", dout, ARR);
    erase_cmd(8'h55, 1'b0);
    chk("R9 bad sixth pulse aborts", dout, ARR);
    prog_cmd(1'b0); t0 = t_last;
    wr(8'hF0);
    wr(8'hB0);
    wait_to(t0 + P - 1);
    chk("R9 writes ignored in program", {7'd0, dout[7]}, 8'd0);
    wait_to(t0 + P);
    chk("R9 program ends on time", dout, ARR);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule